// File: doc/BRIEF.md
# Triggered Segment Playback Sequencer

This block replays a stretch of stored samples once in every pattern period of a repeating frame. A sample memory of 4096 words by 14 bits is filled through a plain write port before playback. Configuration inputs choose the first and last memory address of the stretch, a start delay counted in clock cycles, the length of the pattern period, and an idle code to present while no sample is being played.

Raising the trigger input starts the first period. Each period opens with the start delay, during which nothing is read. Then the address counter walks upward from the start address, one word per clock, until the stop address is reached or the period runs out. For the rest of the period the output carries the idle code with the valid flag low. Periods follow one another back to back for as long as the trigger is high at the last cycle of a period. The configuration is captured at the start of each period, so software may rewrite it at any time without disturbing the period already under way.

Top module: `spq_player`

## Requirements
- R1: The memory holds 4096 words of 14 bits; a word written through the write port while playback is stopped is the value later played from that address, for every address 0 to 4095.
- R2: With the sequencer stopped, the clock edge at which the trigger is sampled high starts a period; calling the cycle after that edge in-period cycle 0, the sample issued in in-period cycle t appears on the output after the next clock edge.
- R3: Within a period the addresses played are start, start+1, ... up to the stop address inclusive, each exactly once, in increasing order.
- R4: During the first D in-period cycles (D being the start delay) no sample is played, so the first sample is issued in in-period cycle D.
- R5: If the trigger is high at the last cycle of a period, the next period starts right away at the following edge; if it is low there, playback stops after that period; trigger changes at any other moment of a running period have no effect.
- R6: Whenever no sample is being played, the valid flag is 0 and the data output equals the idle code input as sampled at the previous clock edge.
- R7: With a start delay of 0 and a period equal to the segment length, samples are output on every cycle across period boundaries with no gap.
- R8: When the period is shorter than the start delay plus the segment length, readout stops at the period boundary and the next period starts again at the start address.
- R9: A stop address below the start address plays a single word, the one at the start address.
- R10: Start address, stop address, start delay and period length are captured at the edge that starts each period; changing them during the period does not change that period's output.
- R11: A period length of 0 behaves as a period of one cycle.
- R12: During reset the valid flag is 0 and the data output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig | input | 1 | Playback trigger, level sensitive |
| cfg_start_addr | input | 12 | First memory address of the segment |
| cfg_stop_addr | input | 12 | Last memory address of the segment |
| cfg_start_dly | input | 16 | Cycles to wait at the opening of each period |
| cfg_period | input | 16 | Pattern period length in cycles |
| cfg_idle_code | input | 14 | Output value while no sample is played |
| mem_we | input | 1 | Memory write strobe |
| mem_waddr | input | 12 | Memory write address |
| mem_wdata | input | 14 | Memory write data |
| smp_data | output | 14 | Sample or idle code |
| smp_valid | output | 1 | High when smp_data carries a stored sample |

## Verification
The bench aims at the period edges: a segment longer than the time left after the delay (a design that kept reading would leak samples into the next period or start it from a stale address), a zero delay with the segment exactly filling the period (an off-by-one in the wrap would open a one-cycle gap or repeat a word), and a period of zero (a counter that did not clamp it would run through the whole counter range). A stop address below the start address checks that a reversed segment plays one word instead of wrapping across the whole memory. A trigger pulse dropped in mid-period and configuration rewritten right after the start edge catch a design that sampled either at the wrong moment, and a segment ending on the top address catches address truncation.

// File: rtl/spq_pkg.sv
package spq_pkg;

   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } spq_state_e;

endpackage

// File: rtl/spq_sample_ram.sv
module spq_sample_ram #(
   parameter int AW = 12,
   parameter int DW = 14
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) store[waddr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (re) rdata <= store[raddr];
   end

endmodule

// File: rtl/spq_period_timer.sv
module spq_period_timer
   import spq_pkg::*;
#(
   parameter int AW = 12,
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          trig,
   input  logic [AW-1:0] cfg_start,
   input  logic [AW-1:0] cfg_stop,
   input  logic [CW-1:0] cfg_dly,
   input  logic [CW-1:0] cfg_per,
   output logic          run,
   output logic          last,
   output logic          per_start,
   output logic [CW-1:0] pcnt,
   output logic [CW-1:0] dly_l,
   output logic [AW:0]   len_l
);
   localparam int LW = AW + 1;

   spq_state_e    st_q;
   logic [CW-1:0] pcnt_q, per_q, dly_q;
   logic [LW-1:0] len_q;
   logic [CW-1:0] per_eff;
   logic [LW-1:0] len_new;

   always_comb begin
      per_eff = (cfg_per == '0) ? CW'(1) : cfg_per;
      if (cfg_stop >= cfg_start)
         len_new = {1'b0, cfg_stop} - {1'b0, cfg_start} + LW'(1);
      else
         len_new = LW'(1);
   end

   assign last      = (pcnt_q == per_q - CW'(1));
   assign per_start = trig && ((st_q == ST_IDLE) || last);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         pcnt_q <= '0;
         per_q  <= CW'(1);
         dly_q  <= '0;
         len_q  <= LW'(1);
      end else if (per_start) begin
         st_q   <= ST_RUN;
         pcnt_q <= '0;
         per_q  <= per_eff;
         dly_q  <= cfg_dly;
         len_q  <= len_new;
      end else if (st_q == ST_RUN) begin
         if (last) st_q   <= ST_IDLE;
         else      pcnt_q <= pcnt_q + CW'(1);
      end
   end

   assign run   = (st_q == ST_RUN);
   assign pcnt  = pcnt_q;
   assign dly_l = dly_q;
   assign len_l = len_q;

endmodule

// File: rtl/spq_addr_gen.sv
module spq_addr_gen #(
   parameter int AW = 12,
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          per_start,
   input  logic [AW-1:0] cfg_start,
   input  logic [CW-1:0] pcnt,
   input  logic [CW-1:0] dly_l,
   input  logic [AW:0]   len_l,
   output logic          rd_en,
   output logic [AW-1:0] rd_addr
);
   localparam int LW = AW + 1;

   logic [CW-1:0] offset;
   logic [CW-1:0] len_ext;
   logic [AW-1:0] addr_q;

   assign offset  = pcnt - dly_l;
   assign len_ext = {{(CW-LW){1'b0}}, len_l};
   assign rd_en   = run && (pcnt >= dly_l) && (offset < len_ext);

   always_ff @(posedge clk) begin
      if (!rst_n)         addr_q <= '0;
      else if (per_start) addr_q <= cfg_start;
      else if (rd_en)     addr_q <= addr_q + AW'(1);
   end

   assign rd_addr = addr_q;

endmodule

// File: rtl/spq_player.sv
module spq_player #(
   parameter int AW = 12,
   parameter int DW = 14,
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          trig,
   input  logic [AW-1:0] cfg_start_addr,
   input  logic [AW-1:0] cfg_stop_addr,
   input  logic [CW-1:0] cfg_start_dly,
   input  logic [CW-1:0] cfg_period,
   input  logic [DW-1:0] cfg_idle_code,
   input  logic          mem_we,
   input  logic [AW-1:0] mem_waddr,
   input  logic [DW-1:0] mem_wdata,
   output logic [DW-1:0] smp_data,
   output logic          smp_valid
);
   generate
      if (AW < 1 || AW > 16) begin : g_bad_aw
         $error("spq_player: AW out of range");
      end
      if (DW < 1) begin : g_bad_dw
         $error("spq_player: DW must be positive");
      end
      if (CW < AW + 2) begin : g_bad_cw
         $error("spq_player: CW must exceed AW by at least two");
      end
   endgenerate

   logic          run, last, per_start, rd_en;
   logic [CW-1:0] pcnt, dly_l;
   logic [AW:0]   len_l;
   logic [AW-1:0] rd_addr;
   logic [DW-1:0] ram_q, idle_q;
   logic          valid_q;

   spq_period_timer #(.AW(AW), .CW(CW)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .trig      (trig),
      .cfg_start (cfg_start_addr),
      .cfg_stop  (cfg_stop_addr),
      .cfg_dly   (cfg_start_dly),
      .cfg_per   (cfg_period),
      .run       (run),
      .last      (last),
      .per_start (per_start),
      .pcnt      (pcnt),
      .dly_l     (dly_l),
      .len_l     (len_l)
   );

   spq_addr_gen #(.AW(AW), .CW(CW)) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .per_start (per_start),
      .cfg_start (cfg_start_addr),
      .pcnt      (pcnt),
      .dly_l     (dly_l),
      .len_l     (len_l),
      .rd_en     (rd_en),
      .rd_addr   (rd_addr)
   );

   spq_sample_ram #(.AW(AW), .DW(DW)) u_ram (
      .clk   (clk),
      .we    (mem_we),
      .waddr (mem_waddr),
      .wdata (mem_wdata),
      .re    (rd_en),
      .raddr (rd_addr),
      .rdata (ram_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         idle_q  <= '0;
      end else begin
         valid_q <= rd_en;
         idle_q  <= cfg_idle_code;
      end
   end

   assign smp_valid = valid_q;
   assign smp_data  = valid_q ? ram_q : idle_q;

endmodule

// File: rtl/spq_player_chk.sv
module spq_player_chk #(
   parameter int AW = 12,
   parameter int DW = 14,
   parameter int CW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          trig,
   input logic [DW-1:0] cfg_idle_code,
   input logic [DW-1:0] smp_data,
   input logic          smp_valid,
   input logic          run,
   input logic          last,
   input logic [CW-1:0] pcnt,
   input logic [CW-1:0] dly_l,
   input logic          rd_en,
   input logic [AW-1:0] rd_addr
);

   a_r2_trigger_starts: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && trig) |=> (run && pcnt == '0));

   a_r3_addr_steps_up: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && $past(rd_en) && pcnt != '0) |-> (rd_addr == $past(rd_addr) + AW'(1)));

   a_r4_no_read_in_delay: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> (pcnt >= dly_l));

   a_r5_stop_on_low_trig: assert property (@(posedge clk) disable iff (!rst_n)
      (run && last && !trig) |=> !run);

   a_r5_period_counts: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !last) |=> (run && pcnt == $past(pcnt) + CW'(1)));

   a_r6_idle_code_out: assert property (@(posedge clk) disable iff (!rst_n)
      (!smp_valid && $past(rst_n)) |-> (smp_data == $past(cfg_idle_code)));

   a_r2_valid_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> smp_valid);

endmodule

bind spq_player spq_player_chk #(.AW(AW), .DW(DW), .CW(CW)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .trig          (trig),
   .cfg_idle_code (cfg_idle_code),
   .smp_data      (smp_data),
   .smp_valid     (smp_valid),
   .run           (run),
   .last          (last),
   .pcnt          (pcnt),
   .dly_l         (dly_l),
   .rd_en         (rd_en),
   .rd_addr       (rd_addr)
);

// File: tb/spq_player_bench.sv
`timescale 1ns/1ps
module spq_player_bench;
   localparam int AW = 12;
   localparam int DW = 14;
   localparam int CW = 16;
   localparam int DEPTH = 1 << AW;
   localparam int TAIL = 4;

   typedef struct {
      logic          v;
      logic [DW-1:0] d;
      string         tag;
   } item_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          trig = 1'b0;
   logic [AW-1:0] cfg_start_addr = '0;
   logic [AW-1:0] cfg_stop_addr = '0;
   logic [CW-1:0] cfg_start_dly = '0;
   logic [CW-1:0] cfg_period = '0;
   logic [DW-1:0] cfg_idle_code = 14'h2000;
   logic          mem_we = 1'b0;
   logic [AW-1:0] mem_waddr = '0;
   logic [DW-1:0] mem_wdata = '0;
   logic [DW-1:0] smp_data;
   logic          smp_valid;

   logic [DW-1:0] model [DEPTH];
   item_t         sb_q[$];
   int            n_run = 0;
   int            n_fail = 0;
   bit            done = 1'b0;

   always #2.5 clk = ~clk;

   spq_player #(.AW(AW), .DW(DW), .CW(CW)) u_spq_player (
      .clk            (clk),
      .rst_n          (rst_n),
      .trig           (trig),
      .cfg_start_addr (cfg_start_addr),
      .cfg_stop_addr  (cfg_stop_addr),
      .cfg_start_dly  (cfg_start_dly),
      .cfg_period     (cfg_period),
      .cfg_idle_code  (cfg_idle_code),
      .mem_we         (mem_we),
      .mem_waddr      (mem_waddr),
      .mem_wdata      (mem_wdata),
      .smp_data       (smp_data),
      .smp_valid      (smp_valid)
   );

   // monitor: one scoreboard item per clock edge after it was queued
   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         item_t it;
         it = sb_q.pop_front();
         n_run++;
         if (smp_valid !== it.v || smp_data !== it.d) begin
            n_fail++;
            $display("FAIL %s: actual valid=%0b data=%h expected valid=%0b data=%h",
                     it.tag, smp_valid, smp_data, it.v, it.d);
         end
      end
   end

   task automatic mem_write(input int a, input logic [DW-1:0] d);
      @(negedge clk);
      mem_we = 1'b1;
      mem_waddr = AW'(a);
      mem_wdata = d;
      model[a] = d;
      @(posedge clk);
      #1 mem_we = 1'b0;
   endtask

   // driver: queues the expected samples, then runs n periods
   task automatic play(input int st, input int sp, input int dly, input int per,
                       input int nper, input bit glitch, input bit scramble,
                       input string tag);
      int peff, len, total;
      peff = (per == 0) ? 1 : per;
      len  = (sp >= st) ? sp - st + 1 : 1;
      total = nper * peff + TAIL;
      @(negedge clk);
      cfg_start_addr = AW'(st);
      cfg_stop_addr  = AW'(sp);
      cfg_start_dly  = CW'(dly);
      cfg_period     = CW'(per);
      trig = 1'b1;
      @(posedge clk);
      @(negedge clk);
      #1;
      for (int s = 0; s < total; s++) begin
         item_t it;
         int t;
         t = s % peff;
         it.tag = tag;
         it.v = (s < nper * peff) && (t >= dly) && (t - dly < len);
         it.d = it.v ? model[(st + t - dly) % DEPTH] : cfg_idle_code;
         sb_q.push_back(it);
      end
      if (scramble) begin
         cfg_start_addr = '0;
         cfg_stop_addr  = '1;
         cfg_start_dly  = '0;
         cfg_period     = CW'(3);
      end
      for (int c = 0; c < total; c++) begin
         if (c > 0) begin
            @(posedge clk);
            @(negedge clk);
            #1;
         end
         trig = (c + 1 < nper * peff) && !(glitch && c >= 2 && c <= 4);
      end
      while (sb_q.size() > 0) @(negedge clk);
      cfg_start_addr = AW'(st);
      cfg_stop_addr  = AW'(sp);
      cfg_start_dly  = CW'(dly);
      cfg_period     = CW'(per);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      n_run++;
      if (smp_valid !== 1'b0 || smp_data !== '0) begin
         n_fail++;
         $display("FAIL R12: actual valid=%0b data=%h expected valid=0 data=0000",
                  smp_valid, smp_data);
      end
      rst_n = 1'b1;
      // R1 preload the whole memory with a computed pattern
      for (int a = 0; a < DEPTH; a++)
         mem_write(a, DW'((a * 37 + 5) ^ (a >> 3)));
      mem_write(12, 14'h3abc);
      mem_write(4095, 14'h1234);
      repeat (3) @(posedge clk);
      // R6 idle output before any trigger
      @(negedge clk);
      n_run++;
      if (smp_valid !== 1'b0 || smp_data !== cfg_idle_code) begin
         n_fail++;
         $display("FAIL R6: actual valid=%0b data=%h expected valid=0 data=%h",
                  smp_valid, smp_data, cfg_idle_code);
      end
      play(10, 17, 3, 15, 2, 1'b1, 1'b0, "R3/R4/R5 delayed segment, trig glitch");
      play(100, 104, 0, 5, 3, 1'b0, 1'b0, "R7 continuous no gap");
      cfg_idle_code = 14'h0155;
      play(200, 219, 4, 10, 2, 1'b0, 1'b0, "R8 truncated at boundary, R6 new idle");
      play(50, 40, 2, 6, 2, 1'b0, 1'b0, "R9 reversed segment");
      play(4090, 4095, 1, 8, 1, 1'b0, 1'b1, "R1 top address, R10 cfg rewrite");
      play(5, 9, 0, 0, 3, 1'b0, 1'b0, "R11 zero period");
      play(0, 0, 0, 1, 2, 1'b0, 1'b0, "R2 single cycle period");
      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog (R2 run ends): actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule